// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block picks the address of the next instruction for a core with 32-bit fixed-length instructions. It is purely combinational: from the current program counter, the 16-bit branch offset field, the 26-bit jump target field, a register value and a register-equality flag, it produces the next program counter for the flow selected by a 3-bit flow code. The register comparison itself, fetch and any delay slot handling are done by neighbouring logic.

The block has no state, so there is no state machine. The flow code plays the part of the state: each code is decoded in one `unique case` and drives one path. The six flows are step, branch-if-equal, branch-if-not-equal, jump, jump-and-link and register jump. For the call flow the block also emits the return address together with a write enable and a destination index. That index is fixed to the link register, 31.

Top module: `npc_select`

## Requirements
- R1: With flow code 0 (step), and with the unused codes 6 and 7, `next_pc` equals `pc + 4`, truncated to 32 bits so that 0xFFFFFFFC steps to 0x00000000.
- R2: With flow code 1 (branch-if-equal), `next_pc` is `pc + 4 + (offset * 4)` when `regs_equal` is 1 and `pc + 4` when it is 0.
- R3: With flow code 2 (branch-if-not-equal), `next_pc` is `pc + 4 + (offset * 4)` when `regs_equal` is 0 and `pc + 4` when it is 1.
- R4: The branch offset is sign-extended from bit 15 before it is scaled, so an offset of 0xFFFF moves the target back one instruction, to `pc`.
- R5: With flow code 3 (jump), `next_pc` is built as follows: bits 31:28 come from `pc + 4`, bits 27:2 are the jump target field, and bits 1:0 are 0.
- R6: With flow code 4 (jump-and-link), `next_pc` is formed as in R5. In addition `link_we` is 1, `link_data` is `pc + 4` and `link_idx` is 31.
- R7: With flow code 5 (register jump), `next_pc` equals `jr_addr` in all 32 bits, with its low two bits unchanged.
- R8: `link_we` is 0 for every flow code other than 4, and `link_idx` is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the current instruction |
| flow | input | 3 | Flow code: 0 step, 1 branch-if-equal, 2 branch-if-not-equal, 3 jump, 4 jump-and-link, 5 register jump |
| br_offset | input | 16 | Signed branch distance in instructions |
| jmp_field | input | 26 | Jump target in instruction words within the current 256 MB region |
| jr_addr | input | 32 | Register value used as the target of a register jump |
| regs_equal | input | 1 | 1 when the two compared registers hold equal values |
| next_pc | output | 32 | Address of the next instruction |
| link_data | output | 32 | Return address, `pc + 4` |
| link_we | output | 1 | Write enable for the return address |
| link_idx | output | 5 | Register index for the return address, always 31 |

## Verification
Every output of this block depends only on the present inputs and passes through no register. Each result is therefore due in the same cycle as its stimulus, zero cycles later. The bench changes the inputs on the falling clock edge and reads the outputs 1 ns afterwards, so each sample falls inside the cycle that its stimulus applies to, and no edge lies between stimulus and sample.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int FLOW_W = 3;

    typedef enum logic [FLOW_W-1:0] {
        FLOW_STEP = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_CALL = 3'd4,
        FLOW_RJMP = 3'd5
    } flow_e;

endpackage

// File: rtl/npc_step_add.sv
// Sequential successor: current address plus one instruction width.
module npc_step_add #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] pc_step
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    assign pc_step = pc + STEP;
endmodule

// File: rtl/npc_branch_tgt.sv
// Relative target: sign-extended word offset scaled to bytes, added to pc_step.
module npc_branch_tgt #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  pc_step,
    input  logic [OFF_W-1:0] offset,
    output logic [XLEN-1:0]  target
);
    localparam int EXT_W = XLEN - OFF_W - SHIFT;

    logic [XLEN-1:0] byte_off;

    assign byte_off = {{EXT_W{offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
    assign target   = pc_step + byte_off;
endmodule

// File: rtl/npc_jump_tgt.sv
// Region jump: top bits kept from pc_step, rest from the scaled target field.
module npc_jump_tgt #(
    parameter int XLEN  = 32,
    parameter int TGT_W = 26,
    parameter int SHIFT = 2
) (
    input  logic [XLEN-1:0]  pc_step,
    input  logic [TGT_W-1:0] field,
    output logic [XLEN-1:0]  target
);
    localparam int LOW_W    = TGT_W + SHIFT;
    localparam int REGION_W = XLEN - LOW_W;

    generate
        if (REGION_W > 0) begin : g_region
            assign target = {pc_step[XLEN-1:LOW_W], field, {SHIFT{1'b0}}};
        end else begin : g_flat
            assign target = XLEN'({field, {SHIFT{1'b0}}});
        end
    endgenerate
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int OFF_W      = 16,
    parameter int TGT_W      = 26,
    parameter int INSN_BYTES = 4,
    parameter int RIDX_W     = 5,
    parameter int LINK_REG   = 31
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [FLOW_W-1:0] flow,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [TGT_W-1:0]  jmp_field,
    input  logic [XLEN-1:0]   jr_addr,
    input  logic              regs_equal,
    output logic [XLEN-1:0]   next_pc,
    output logic [XLEN-1:0]   link_data,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx
);
    localparam int SHIFT = $clog2(INSN_BYTES);

    logic [XLEN-1:0] pc_step;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    flow_e           flow_code;

    assign flow_code = flow_e'(flow);

    npc_step_add #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES)
    ) u_step (
        .pc      (pc),
        .pc_step (pc_step)
    );

    npc_branch_tgt #(
        .XLEN  (XLEN),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_branch (
        .pc_step (pc_step),
        .offset  (br_offset),
        .target  (br_target)
    );

    npc_jump_tgt #(
        .XLEN  (XLEN),
        .TGT_W (TGT_W),
        .SHIFT (SHIFT)
    ) u_jump (
        .pc_step (pc_step),
        .field   (jmp_field),
        .target  (jmp_target)
    );

    // Flow decode: one path per code; unused codes fall back to a step.
    always_comb begin
        next_pc = pc_step;
        link_we = 1'b0;
        unique case (flow_code)
            FLOW_STEP: next_pc = pc_step;
            FLOW_BEQ:  next_pc = regs_equal ? br_target : pc_step;
            FLOW_BNE:  next_pc = regs_equal ? pc_step : br_target;
            FLOW_JMP:  next_pc = jmp_target;
            FLOW_CALL: begin
                next_pc = jmp_target;
                link_we = 1'b1;
            end
            FLOW_RJMP: next_pc = jr_addr;
            default:   next_pc = pc_step;
        endcase
    end

    assign link_data = pc_step;
    assign link_idx  = RIDX_W'(LINK_REG);

endmodule

// File: rtl/npc_select_chk.sv
module npc_select_chk #(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int TGT_W  = 26,
    parameter int RIDX_W = 5
) (
    input logic [XLEN-1:0]   pc,
    input logic [2:0]        flow,
    input logic [OFF_W-1:0]  br_offset,
    input logic [TGT_W-1:0]  jmp_field,
    input logic [XLEN-1:0]   jr_addr,
    input logic              regs_equal,
    input logic [XLEN-1:0]   next_pc,
    input logic [XLEN-1:0]   link_data,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx
);
    localparam int LOW_W = TGT_W + 2;

    logic [XLEN-1:0] succ;
    logic            known;

    assign succ  = pc + XLEN'(4);
    assign known = !$isunknown({pc, flow, br_offset, jmp_field, jr_addr, regs_equal});

    always_comb begin
        if (known) begin
            p_step_succ_r1: assert ((flow != 3'd0 && flow < 3'd6) || next_pc == succ)
                else $error("step flow did not advance by one instruction");
            p_beq_miss_r2: assert (!(flow == 3'd1 && !regs_equal) || next_pc == succ)
                else $error("untaken equal branch left the sequence");
            p_bne_miss_r3: assert (!(flow == 3'd2 && regs_equal) || next_pc == succ)
                else $error("untaken unequal branch left the sequence");
            p_jump_region_r5: assert (!(flow == 3'd3 || flow == 3'd4)
                    || (next_pc[1:0] == 2'b00 && next_pc[XLEN-1:LOW_W] == succ[XLEN-1:LOW_W]))
                else $error("jump target left the current region or is misaligned");
            p_call_link_r6: assert (!link_we || link_data == succ)
                else $error("return address differs from pc plus 4");
            p_rjmp_full_r7: assert (flow != 3'd5 || next_pc == jr_addr)
                else $error("register jump did not take the full register value");
            p_link_only_call_r8: assert (link_we == (flow == 3'd4))
                else $error("link write enable outside the call flow");
            p_link_idx_nonzero_r8: assert (link_idx != '0)
                else $error("link index points at register 0");
        end
    end
endmodule

bind npc_select npc_select_chk #(
    .XLEN   (XLEN),
    .OFF_W  (OFF_W),
    .TGT_W  (TGT_W),
    .RIDX_W (RIDX_W)
) u_chk (
    .pc         (pc),
    .flow       (flow),
    .br_offset  (br_offset),
    .jmp_field  (jmp_field),
    .jr_addr    (jr_addr),
    .regs_equal (regs_equal),
    .next_pc    (next_pc),
    .link_data  (link_data),
    .link_we    (link_we),
    .link_idx   (link_idx)
);

// File: tb/npc_select_bench.sv
`timescale 1ns/1ps
module npc_select_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc;
    logic [2:0]  flow;
    logic [15:0] br_offset;
    logic [25:0] jmp_field;
    logic [31:0] jr_addr;
    logic        regs_equal;
    logic [31:0] next_pc;
    logic [31:0] link_data;
    logic        link_we;
    logic [4:0]  link_idx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    npc_select u_npc_select (
        .pc         (pc),
        .flow       (flow),
        .br_offset  (br_offset),
        .jmp_field  (jmp_field),
        .jr_addr    (jr_addr),
        .regs_equal (regs_equal),
        .next_pc    (next_pc),
        .link_data  (link_data),
        .link_we    (link_we),
        .link_idx   (link_idx)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Apply inputs on the falling edge, read 1 ns later.
    task automatic apply(input logic [31:0] p, input logic [2:0] f, input logic [15:0] o,
                         input logic [25:0] t, input logic [31:0] r, input logic e);
        @(negedge clk);
        pc = p; flow = f; br_offset = o; jmp_field = t; jr_addr = r; regs_equal = e;
        #1;
    endtask

    function automatic logic [31:0] rel_tgt(input logic [31:0] p, input logic [15:0] o);
        logic signed [31:0] words = 32'(signed'(o));
        return p + 32'd4 + (words * 4);
    endfunction

    task automatic t_reset_state();
        check("R1", "reset next_pc", next_pc, 32'h4);
        check("R8", "reset link_we", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_step_r1();
        apply(32'h0000_1000, 3'd0, 16'h0010, 26'h3, 32'h55, 1'b1);
        check("R1", "step", next_pc, 32'h0000_1004);
        apply(32'hFFFF_FFFC, 3'd0, 16'h0, 26'h0, 32'h0, 1'b0);
        check("R1", "step wrap", next_pc, 32'h0);
        for (int c = 6; c < 8; c++) begin
            apply(32'h0040_0020, 3'(c), 16'h7, 26'h1, 32'hDEAD_BEEF, 1'b1);
            check("R1", "unused code", next_pc, 32'h0040_0024);
        end
    endtask

    task automatic t_beq_r2();
        apply(32'h0000_2000, 3'd1, 16'd25, 26'h0, 32'h0, 1'b1);
        check("R2", "beq taken", next_pc, rel_tgt(32'h0000_2000, 16'd25));
        apply(32'h0000_2000, 3'd1, 16'd25, 26'h0, 32'h0, 1'b0);
        check("R2", "beq not taken", next_pc, 32'h0000_2004);
    endtask

    task automatic t_bne_r3();
        apply(32'h0001_0000, 3'd2, 16'h7FFF, 26'h0, 32'h0, 1'b0);
        check("R3", "bne taken max fwd", next_pc, 32'h0001_0004 + 32'h0001_FFFC);
        apply(32'h0001_0000, 3'd2, 16'h7FFF, 26'h0, 32'h0, 1'b1);
        check("R3", "bne not taken", next_pc, 32'h0001_0004);
    endtask

    task automatic t_backward_r4();
        apply(32'h0000_3000, 3'd1, 16'hFFFF, 26'h0, 32'h0, 1'b1);
        check("R4", "offset -1 self", next_pc, 32'h0000_3000);
        apply(32'h0002_0000, 3'd2, 16'h8000, 26'h0, 32'h0, 1'b0);
        check("R4", "max backward", next_pc, 32'h0002_0004 - 32'h0002_0000);
        apply(32'h0000_0008, 3'd1, 16'hFFFC, 26'h0, 32'h0, 1'b1);
        check("R4", "below zero wrap", next_pc, 32'hFFFF_FFFC);
    endtask

    task automatic t_jump_r5();
        apply(32'h4000_1000, 3'd3, 16'h0, 26'h0ABCDEF, 32'h0, 1'b0);
        check("R5", "jump", next_pc, {4'h4, 26'h0ABCDEF, 2'b00});
        check("R8", "jump no link", {31'd0, link_we}, 32'd0);
        apply(32'h0FFF_FFFC, 3'd3, 16'h0, 26'h3FFFFFF, 32'h0, 1'b0);
        check("R5", "region from pc+4", next_pc, {4'h1, 26'h3FFFFFF, 2'b00});
    endtask

    task automatic t_call_r6();
        apply(32'h8000_0400, 3'd4, 16'h0, 26'h0000100, 32'h0, 1'b0);
        check("R6", "call target", next_pc, 32'h8000_0400);
        check("R6", "call link_we", {31'd0, link_we}, 32'd1);
        check("R6", "call link_data", link_data, 32'h8000_0404);
        check("R6", "call link_idx", {27'd0, link_idx}, 32'd31);
    endtask

    task automatic t_rjmp_r7();
        apply(32'h0000_5000, 3'd5, 16'h1234, 26'h1, 32'h1234_5677, 1'b1);
        check("R7", "register jump full value", next_pc, 32'h1234_5677);
        check("R8", "register jump no link", {31'd0, link_we}, 32'd0);
    endtask

    task automatic t_link_r8();
        for (int c = 0; c < 8; c++) begin
            if (c != 4) begin
                apply(32'h0000_0100, 3'(c), 16'h2, 26'h2, 32'h300, 1'b1);
                check("R8", "link_we off", {31'd0, link_we}, 32'd0);
                check("R8", "link_idx", {27'd0, link_idx}, 32'd31);
            end
        end
    endtask

    initial begin
        pc = '0; flow = '0; br_offset = '0; jmp_field = '0; jr_addr = '0; regs_equal = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        t_reset_state();
        t_step_r1();
        t_beq_r2();
        t_bne_r3();
        t_backward_r4();
        t_jump_r5();
        t_call_r6();
        t_rjmp_r7();
        t_link_r8();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule